// File: doc/BRIEF.md
# Integer Execute Unit with Barrel Shifter

This block is the arithmetic and logic stage of a simple load-store RISC core. On every clock it takes a 6-bit opcode, a 6-bit function code, two register operands, a 16-bit immediate and a 5-bit shift count. One cycle later it presents the computed word and a flag that is high when that word is zero.

The supported operations are logical AND, OR and NOR, and AND and OR with an immediate. There are left and right shifts that fill with zeros, and a right shift that copies the sign bit. Add and subtract wrap around. Set-less-than comes in signed and unsigned forms, each with a register or an immediate as the second operand. A bitwise complement has no code of its own: software issues NOR with a zero operand. Fetch, register storage, memory and pipeline control belong to the surrounding core.

Top module: `rx_exec_unit`

## Requirements
- R1: With opcode 0x00 and function 0x24, `result` is `opa & opb`. With function 0x25 it is `opa | opb`.
- R2: With opcode 0x00 and function 0x27, `result` is `~(opa | opb)`. When `opb` is zero this gives the bitwise complement of `opa`.
- R3: Opcode 0x0C (AND immediate) and opcode 0x0D (OR immediate) combine `opa` with `imm` extended by sixteen zero bits.
- R4: Opcode 0x08 (add immediate) adds `imm`, sign-extended, to `opa`.
- R5: Opcode 0x0A compares `opa` with the sign-extended `imm` as signed numbers. Opcode 0x0B compares them as unsigned numbers.
- R6: With opcode 0x00 and function 0x00, `result` is `opb` shifted left by `shamt` (0 to 31 places), with zeros filling the vacated low bits.
- R7: With opcode 0x00 and function 0x02, `result` is `opb` shifted right by `shamt`, with zeros filling the vacated high bits.
- R8: With opcode 0x00 and function 0x03, `result` is `opb` shifted right by `shamt`, with copies of `opb[31]` filling the vacated high bits.
- R9: With opcode 0x00, function 0x2A is the signed `opa < opb` test and function 0x2B is the unsigned test. Each returns the word 1 when the condition holds and 0 otherwise. For example, `opa`=0xFFFFFFFF and `opb`=0x00000001 give 1 for the signed test and 0 for the unsigned test.
- R10: With opcode 0x00, function 0x20 returns `opa + opb` and function 0x22 returns `opa - opb`, both modulo 2^32, with no trap.
- R11: `zero` is high exactly when `result` is 0.
- R12: Any opcode or function code not listed above yields `result` = 0.
- R13: Results appear one clock after the inputs are applied. While `rst` is high, the next edge sets `result` to 0 and `zero` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Primary operation code |
| funct | input | 6 | Function code used when opcode is 0 |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand, also the shift source |
| imm | input | 16 | Immediate constant |
| shamt | input | 5 | Shift count |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered flag, high when result is 0 |

## Verification
The bench builds the unit with its default width of 32 bits, which makes the shift count 5 bits wide. Every shift distance from 0 to 31 is therefore reachable, including the two ends, where the output equals the input and where a single bit survives. At this width the sign-extension and zero-extension boundaries of the 16-bit immediate can be exercised with 0x7FFF, 0x8000 and 0xFFFF. The all-ones versus one operand pair shows where the signed and unsigned comparisons disagree.

// File: rtl/rx_alu_pkg.sv
package rx_alu_pkg;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_SLTIU = 6'h0B;
  localparam logic [5:0] OPC_ANDI  = 6'h0C;
  localparam logic [5:0] OPC_ORI   = 6'h0D;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    K_NONE, K_AND, K_OR, K_NOR, K_ADD, K_SUB,
    K_SLT, K_SLTU, K_SLL, K_SRL, K_SRA
  } alu_kind_e;

  typedef enum logic [1:0] {
    SRC_REG, SRC_IMM_ZX, SRC_IMM_SX
  } src_sel_e;

endpackage

// File: rtl/rx_decode.sv
module rx_decode
  import rx_alu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output alu_kind_e  kind,
  output src_sel_e   src
);

  always_comb begin
    kind = K_NONE;
    src  = SRC_REG;
    case (opcode)
      OPC_RTYPE: begin
        case (funct)
          FN_SLL:  kind = K_SLL;
          FN_SRL:  kind = K_SRL;
          FN_SRA:  kind = K_SRA;
          FN_ADD:  kind = K_ADD;
          FN_SUB:  kind = K_SUB;
          FN_AND:  kind = K_AND;
          FN_OR:   kind = K_OR;
          FN_NOR:  kind = K_NOR;
          FN_SLT:  kind = K_SLT;
          FN_SLTU: kind = K_SLTU;
          default: kind = K_NONE;
        endcase
      end
      OPC_ADDI:  begin kind = K_ADD;  src = SRC_IMM_SX; end
      OPC_SLTI:  begin kind = K_SLT;  src = SRC_IMM_SX; end
      OPC_SLTIU: begin kind = K_SLTU; src = SRC_IMM_SX; end
      OPC_ANDI:  begin kind = K_AND;  src = SRC_IMM_ZX; end
      OPC_ORI:   begin kind = K_OR;   src = SRC_IMM_ZX; end
      default:   begin kind = K_NONE; src = SRC_REG;    end
    endcase
  end

endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [W-1:0]  dout
);

  logic          fill;
  logic [W-1:0]  pre;
  logic [W-1:0]  stg [0:SW];

  assign fill = arith & ~left & din[W-1];

  // Left shifts run through the right-shift network on a mirrored word.
  for (genvar i = 0; i < W; i++) begin : g_mirror_in
    assign pre[i] = left ? din[W-1-i] : din[i];
  end

  assign stg[0] = pre;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stg[k+1] = amt[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
  end

  for (genvar i = 0; i < W; i++) begin : g_mirror_out
    assign dout[i] = left ? stg[SW][W-1-i] : stg[SW][i];
  end

  always_comb begin
    // R6
    if (amt == '0) begin
      shift_zero_identity_chk: assert (dout == din);
    end
  end

endmodule

// File: rtl/rx_exec_unit.sv
module rx_exec_unit
  import rx_alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [5:0]         opcode,
  input  logic [5:0]         funct,
  input  logic [DATA_W-1:0]  opa,
  input  logic [DATA_W-1:0]  opb,
  input  logic [IMM_W-1:0]   imm,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  result,
  output logic               zero
);

  localparam int EXT_W = DATA_W - IMM_W;

  alu_kind_e         kind;
  src_sel_e          src;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] sh_out;
  logic [DATA_W-1:0] nxt;

  rx_decode u_dec (
    .opcode (opcode),
    .funct  (funct),
    .kind   (kind),
    .src    (src)
  );

  rx_shifter #(.W(DATA_W), .SW(SHAMT_W)) u_shf (
    .din   (opb),
    .amt   (shamt),
    .left  (kind == K_SLL),
    .arith (kind == K_SRA),
    .dout  (sh_out)
  );

  always_comb begin
    case (src)
      SRC_IMM_ZX: b_eff = {{EXT_W{1'b0}}, imm};
      SRC_IMM_SX: b_eff = {{EXT_W{imm[IMM_W-1]}}, imm};
      default:    b_eff = opb;
    endcase
  end

  always_comb begin
    case (kind)
      K_AND:   nxt = opa & b_eff;
      K_OR:    nxt = opa | b_eff;
      K_NOR:   nxt = ~(opa | b_eff);
      K_ADD:   nxt = opa + b_eff;
      K_SUB:   nxt = opa - b_eff;
      K_SLT:   nxt = {{(DATA_W-1){1'b0}}, $signed(opa) < $signed(b_eff)};
      K_SLTU:  nxt = {{(DATA_W-1){1'b0}}, opa < b_eff};
      K_SLL,
      K_SRL,
      K_SRA:   nxt = sh_out;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      zero   <= 1'b1;
    end else begin
      result <= nxt;
      zero   <= (nxt == '0);
    end
  end

  // R13
  reset_clears_chk: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && zero));

  // R11
  zero_flag_match_chk: assert property (@(posedge clk) disable iff (rst)
    zero == (result == '0));

  // R9
  slt_boolean_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(kind) == K_SLT || $past(kind) == K_SLTU))
      |-> result[DATA_W-1:1] == '0);

  // R6
  sll_low_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(kind) == K_SLL && $past(shamt) != '0)
      |-> result[0] == 1'b0);

  // R8
  sra_sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(kind) == K_SRA)
      |-> result[DATA_W-1] == $past(opb[DATA_W-1]));

endmodule

// File: tb/rx_exec_unit_tb.sv
module rx_exec_unit_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    string       req;
    logic [31:0] exp_res;
    logic        exp_zero;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = 6'h00;
  logic [5:0]  funct  = 6'h24;
  logic [31:0] opa = 32'hFFFF_FFFF;
  logic [31:0] opb = 32'hFFFF_FFFF;
  logic [15:0] imm = 16'h0;
  logic [4:0]  shamt = 5'd0;
  logic [31:0] result;
  logic        zero;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  sb_item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_exec_unit u_dut (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
    .opa(opa), .opb(opb), .imm(imm), .shamt(shamt),
    .result(result), .zero(zero)
  );

  // Reference model written from the requirements.
  function automatic logic [31:0] model(input logic [5:0] op, input logic [5:0] fn,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [15:0] k, input logic [4:0] s);
    logic [31:0] sx = {{16{k[15]}}, k};
    logic [31:0] zx = {16'h0, k};
    if (op == 6'h00) begin
      case (fn)
        6'h24: return a & b;
        6'h25: return a | b;
        6'h27: return ~(a | b);
        6'h00: return b << s;
        6'h02: return b >> s;
        6'h03: return $unsigned($signed(b) >>> s);
        6'h20: return a + b;
        6'h22: return a - b;
        6'h2A: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        6'h2B: return (a < b) ? 32'd1 : 32'd0;
        default: return 32'd0;
      endcase
    end
    case (op)
      6'h08: return a + sx;
      6'h0A: return ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
      6'h0B: return (a < sx) ? 32'd1 : 32'd0;
      6'h0C: return a & zx;
      6'h0D: return a | zx;
      default: return 32'd0;
    endcase
  endfunction

  task automatic issue(input string req, input logic [5:0] op, input logic [5:0] fn,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] k, input logic [4:0] s);
    sb_item_t it;
    @(negedge clk);
    opcode = op; funct = fn; opa = a; opb = b; imm = k; shamt = s;
    it.req      = req;
    it.exp_res  = model(op, fn, a, b, k, s);
    it.exp_zero = (it.exp_res == 32'd0);
    exp_q.push_back(it);
  endtask

  // Monitor: one item is consumed just after the edge that registers it.
  always @(posedge clk) begin
    #1;
    if (!rst && exp_q.size() > 0) begin
      sb_item_t it;
      it = exp_q.pop_front();
      n_checks++;
      if (result !== it.exp_res) begin
        n_fail++;
        $display("FAIL %s result actual=%h expected=%h", it.req, result, it.exp_res);
      end
      n_checks++;
      // R11 zero flag accompanies every result
      if (zero !== it.exp_zero) begin
        n_fail++;
        $display("FAIL R11 (%s) zero actual=%b expected=%b", it.req, zero, it.exp_zero);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (result !== 32'd0 || zero !== 1'b1) begin
      n_fail++;
      $display("FAIL R13 reset actual=%h/%b expected=00000000/1", result, zero);
    end
    rst = 1'b0;

    issue("R1",  6'h00, 6'h24, 32'h0000_3C00, 32'h0000_0DC0, 16'h0, 5'd0);
    issue("R1",  6'h00, 6'h25, 32'h0000_3C00, 32'h0000_0DC0, 16'h0, 5'd0);
    issue("R2",  6'h00, 6'h27, 32'h0000_3C00, 32'h0000_0000, 16'h0, 5'd0);
    issue("R2",  6'h00, 6'h27, 32'hFFFF_FFFF, 32'h0000_0000, 16'h0, 5'd0);
    issue("R3",  6'h0C, 6'h3F, 32'hFFFF_FFFF, 32'h0,         16'hFF00, 5'd7);
    issue("R3",  6'h0D, 6'h00, 32'h1234_0000, 32'hFFFF_FFFF, 16'h8001, 5'd0);
    issue("R4",  6'h08, 6'h00, 32'd5,         32'h0,         16'hFFFF, 5'd0);
    issue("R4",  6'h08, 6'h00, 32'd1,         32'h0,         16'h7FFF, 5'd0);
    issue("R4",  6'h08, 6'h00, 32'h0,         32'h0,         16'h8000, 5'd0);
    issue("R5",  6'h0A, 6'h00, 32'hFFFF_FFFE, 32'h0,         16'hFFFF, 5'd0);
    issue("R5",  6'h0B, 6'h00, 32'hFFFF_FFFE, 32'h0,         16'hFFFF, 5'd0);
    issue("R5",  6'h0A, 6'h00, 32'd15,        32'h0,         16'd15,   5'd0);
    issue("R6",  6'h00, 6'h00, 32'h0, 32'hA5A5_0F0F, 16'h0, 5'd0);
    issue("R6",  6'h00, 6'h00, 32'h0, 32'h0000_0003, 16'h0, 5'd31);
    issue("R6",  6'h00, 6'h00, 32'h0, 32'h00AB_CDEF, 16'h0, 5'd8);
    issue("R7",  6'h00, 6'h02, 32'h0, 32'hABCD_EF01, 16'h0, 5'd24);
    issue("R7",  6'h00, 6'h02, 32'h0, 32'h8000_0000, 16'h0, 5'd31);
    issue("R8",  6'h00, 6'h03, 32'h0, 32'h8000_0000, 16'h0, 5'd31);
    issue("R8",  6'h00, 6'h03, 32'h0, 32'hF0F0_0000, 16'h0, 5'd4);
    issue("R8",  6'h00, 6'h03, 32'h0, 32'h7000_0000, 16'h0, 5'd28);
    issue("R9",  6'h00, 6'h2A, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0, 5'd0);
    issue("R9",  6'h00, 6'h2B, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0, 5'd0);
    issue("R9",  6'h00, 6'h2A, 32'd7, 32'd7, 16'h0, 5'd0);
    issue("R10", 6'h00, 6'h20, 32'hFFFF_FFFF, 32'd2, 16'h0, 5'd0);
    issue("R10", 6'h00, 6'h22, 32'd0, 32'd1, 16'h0, 5'd0);
    issue("R11", 6'h00, 6'h22, 32'h1357_9BDF, 32'h1357_9BDF, 16'h0, 5'd0);
    issue("R12", 6'h3F, 6'h24, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd3);
    issue("R12", 6'h00, 6'h21, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
    issue("R13", 6'h00, 6'h25, 32'h0000_0001, 32'h0, 16'h0, 5'd0);

    @(negedge clk);
    @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL R13 pending results actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R13 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule